// File: doc/BRIEF.md
# FIFO DMA Request Arbiter

This block drives the DMA request line for the 16-byte FIFO data port of a parallel port controller. It also turns acknowledged host bus cycles into single-cycle push and pop strobes for the FIFO. The request is raised only while the port runs in one of its FIFO modes, DMA is enabled, and the service-interrupt bit is clear. It is then qualified by the transfer direction against the FIFO full or empty flag, or forced on in the test mode.

A terminal count that arrives during an acknowledged cycle asks the control register to set the service-interrupt bit. The request drops in that same clock. In ECP reverse transfers, the block also pushes peripheral bytes, tagged with the peripheral's busy level, on the trailing edge of the reverse handshake strobe. The FIFO storage and the choice among request channels live outside the block.

All inputs are synchronous to `clk`. The request and the service-bit request are combinational from the present inputs. Strobe edges are found by comparing each strobe with its level in the previous clock.

Top module: `fifo_dma_arb`

## Requirements
- R1: The 3-bit `mode` field selects a FIFO mode only for the codes 3'b010 (forward byte FIFO), 3'b011 (ECP) and 3'b110 (test). For every other code, `dreq`, `set_svc`, `fifo_push` and `fifo_pop` stay low.
- R2: In a FIFO mode, `dreq` is high exactly when all of the following hold in the same clock:
  - `dma_en` is high, `svc_int` is low and `set_svc` is low.
  - One of these holds: `dir`=0 and `fifo_full`=0, or `dir`=1 and `fifo_empty`=0, or the mode is test.
- R3: A trailing edge of `host_wr_n` produces a one-clock `fifo_push` with `push_src`=0, under three conditions:
  - A trailing edge means low in one clock and high in the next.
  - `dack_n` was low in the last clock the strobe was low.
  - The mode is a FIFO mode and `fifo_full` is low in the edge clock.
- R4: A trailing edge of `host_rd_n`, under the same acknowledge and mode conditions, produces a one-clock `fifo_pop`, provided `fifo_empty` is low in the edge clock.
- R5: In a FIFO mode, with `dma_en` high, `tc` high, `dack_n` low and `svc_int` low, `set_svc` is high and `dreq` is low in that same clock.
- R6: In ECP mode with `dir`=1, a trailing edge of `rev_stb_n` while `fifo_full` is low produces a one-clock `fifo_push`. That push has `push_src`=1 and `push_tag` equal to `periph_busy` in the edge clock. It wins over a host push in the same clock, and that host push is dropped. `push_tag` is 0 whenever `push_src` is 0.
- R7: During reset, all outputs driven from strobe history are low. A strobe that is low during reset and high after release produces no transfer.
- R8: A strobe trailing edge whose low phase saw `dack_n` high produces no host push or pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Port operating mode field |
| dma_en | input | 1 | DMA enable control bit |
| svc_int | input | 1 | Service-interrupt control bit |
| dir | input | 1 | Transfer direction, 1 = peripheral to host |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc | input | 1 | DMA terminal count |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| rev_stb_n | input | 1 | Reverse-transfer handshake strobe, active low |
| periph_busy | input | 1 | Peripheral busy level, stored as tag bit |
| dreq | output | 1 | DMA request |
| set_svc | output | 1 | Request to set the service-interrupt bit |
| fifo_push | output | 1 | One-clock FIFO write strobe |
| fifo_pop | output | 1 | One-clock FIFO read strobe |
| push_src | output | 1 | Push source, 1 = peripheral |
| push_tag | output | 1 | Tag bit stored with a peripheral push |

## Verification
The assertions take for granted that the strobes, `dack_n` and `tc` are synchronous, glitch-free levels held for whole clocks. They also assume every strobe is inactive (high) while reset is applied, except in the one reset-release scenario. The stimulus changes every input only on the falling clock edge and returns all strobes and the acknowledge to their idle level between sequences. The request sweep keeps the strobes idle so that only the gating inputs vary.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMPAT = 3'b000,
        MODE_BIDIR  = 3'b001,
        MODE_BFIFO  = 3'b010,
        MODE_ECP    = 3'b011,
        MODE_EPP    = 3'b100,
        MODE_RSVD   = 3'b101,
        MODE_TEST   = 3'b110,
        MODE_CONF   = 3'b111
    } port_mode_e;

    function automatic logic is_fifo_mode(input logic [MODE_W-1:0] m);
        return (m == MODE_BFIFO) || (m == MODE_ECP) || (m == MODE_TEST);
    endfunction

    function automatic logic is_test_mode(input logic [MODE_W-1:0] m);
        return m == MODE_TEST;
    endfunction

    function automatic logic is_ecp_mode(input logic [MODE_W-1:0] m);
        return m == MODE_ECP;
    endfunction

endpackage

// File: rtl/fdma_edge.sv
module fdma_edge #(
    parameter int N_STB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_STB-1:0] stb_n,
    input  logic             ack_n,
    output logic [N_STB-1:0] trail,
    output logic             ack_held
);

    typedef struct packed {
        logic [N_STB-1:0] stb;
        logic             ack;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d     = hist_q;
        hist_d.stb = stb_n;
        hist_d.ack = ack_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else begin
            hist_q <= hist_d;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_STB; gi++) begin : g_trail
            assign trail[gi] = ~hist_q.stb[gi] & stb_n[gi];

            AST_TRAIL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                trail[gi] |-> ($past(stb_n[gi]) == 1'b0)); // R3
        end
    endgenerate

    assign ack_held = ~hist_q.ack;

endmodule

// File: rtl/fdma_req.sv
module fdma_req
    import fdma_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              dma_en,
    input  logic              svc_int,
    input  logic              dir,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic              tc,
    input  logic              dack_n,
    output logic              dreq,
    output logic              set_svc
);

    logic fmode;
    logic space_ok;
    logic armed;

    always_comb begin
        fmode    = is_fifo_mode(mode);
        space_ok = is_test_mode(mode)
                 | (~dir & ~fifo_full)
                 | ( dir & ~fifo_empty);
        armed    = fmode & dma_en & ~svc_int;
        set_svc  = armed & tc & ~dack_n;
        dreq     = armed & space_ok & ~set_svc;
    end

endmodule

// File: rtl/fdma_xfer.sv
module fdma_xfer
    import fdma_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              dir,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic              wr_trail,
    input  logic              rd_trail,
    input  logic              rev_trail,
    input  logic              ack_held,
    input  logic              periph_busy,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic              push_src,
    output logic              push_tag
);

    logic fmode;
    logic rev_push;
    logic host_push;

    always_comb begin
        fmode     = is_fifo_mode(mode);
        rev_push  = is_ecp_mode(mode) & dir & rev_trail & ~fifo_full;
        host_push = fmode & wr_trail & ack_held & ~fifo_full & ~rev_push;
        fifo_push = rev_push | host_push;
        push_src  = rev_push;
        push_tag  = rev_push & periph_busy;
        fifo_pop  = fmode & rd_trail & ack_held & ~fifo_empty;
    end

endmodule

// File: rtl/fifo_dma_arb.sv
module fifo_dma_arb
    import fdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              dma_en,
    input  logic              svc_int,
    input  logic              dir,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic              dack_n,
    input  logic              tc,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic              rev_stb_n,
    input  logic              periph_busy,
    output logic              dreq,
    output logic              set_svc,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic              push_src,
    output logic              push_tag
);

    localparam int N_STB = 3;
    localparam int IDX_WR  = 0;
    localparam int IDX_RD  = 1;
    localparam int IDX_REV = 2;

    logic [N_STB-1:0] stb_n;
    logic [N_STB-1:0] trail;
    logic             ack_held;

    assign stb_n[IDX_WR]  = host_wr_n;
    assign stb_n[IDX_RD]  = host_rd_n;
    assign stb_n[IDX_REV] = rev_stb_n;

    fdma_edge #(.N_STB(N_STB)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_n    (stb_n),
        .ack_n    (dack_n),
        .trail    (trail),
        .ack_held (ack_held)
    );

    fdma_req u_req (
        .mode       (mode),
        .dma_en     (dma_en),
        .svc_int    (svc_int),
        .dir        (dir),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .tc         (tc),
        .dack_n     (dack_n),
        .dreq       (dreq),
        .set_svc    (set_svc)
    );

    fdma_xfer u_xfer (
        .mode        (mode),
        .dir         (dir),
        .fifo_full   (fifo_full),
        .fifo_empty  (fifo_empty),
        .wr_trail    (trail[IDX_WR]),
        .rd_trail    (trail[IDX_RD]),
        .rev_trail   (trail[IDX_REV]),
        .ack_held    (ack_held),
        .periph_busy (periph_busy),
        .fifo_push   (fifo_push),
        .fifo_pop    (fifo_pop),
        .push_src    (push_src),
        .push_tag    (push_tag)
    );

    AST_IDLE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !is_fifo_mode(mode) |-> !(dreq || set_svc || fifo_push || fifo_pop)); // R1
    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> (dma_en && !svc_int)); // R2
    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full); // R3
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (!fifo_empty && $past(!host_rd_n) && $past(!dack_n))); // R4
    AST_TC_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        set_svc |-> !dreq); // R5
    AST_TAG_ONLY_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        !push_src |-> !push_tag); // R6
    AST_HOST_PUSH_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && !push_src) |-> $past(!dack_n)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !(fifo_push || fifo_pop)); // R7

endmodule

// File: tb/fifo_dma_arb_test.sv
`timescale 1ns/1ps
module fifo_dma_arb_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b000;
    logic       dma_en = 0, svc_int = 0, dir = 0, fifo_full = 0, fifo_empty = 0;
    logic       dack_n = 1, tc = 0, host_wr_n = 1, host_rd_n = 1, rev_stb_n = 1, periph_busy = 0;
    logic       dreq, set_svc, fifo_push, fifo_pop, push_src, push_tag;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fifo_dma_arb uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dma_en(dma_en), .svc_int(svc_int),
        .dir(dir), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .dack_n(dack_n),
        .tc(tc), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n), .rev_stb_n(rev_stb_n),
        .periph_busy(periph_busy), .dreq(dreq), .set_svc(set_svc), .fifo_push(fifo_push),
        .fifo_pop(fifo_pop), .push_src(push_src), .push_tag(push_tag)
    );

    function automatic logic fmode(input logic [2:0] m);
        return (m == 3'b010) || (m == 3'b011) || (m == 3'b110);
    endfunction

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic chk_xfer(input string req, input logic e_push, input logic e_pop,
                            input logic e_src, input logic e_tag);
        chk(req, "fifo_push", fifo_push, e_push);
        chk(req, "fifo_pop",  fifo_pop,  e_pop);
        chk(req, "push_src",  push_src,  e_src);
        chk(req, "push_tag",  push_tag,  e_tag);
    endtask

    // kind: 0 host write, 1 host read, 2 reverse strobe
    task automatic strobe_seq(input int kind, input logic ack_low, input logic busy);
        logic e_push, e_pop, e_src, e_tag;
        @(posedge clk);
        @(negedge clk);
        if (kind == 0) host_wr_n = 0;
        if (kind == 1) host_rd_n = 0;
        if (kind == 2) rev_stb_n = 0;
        dack_n = ~ack_low;
        periph_busy = busy;
        #1 chk_xfer("R3", 0, 0, 0, 0);
        @(negedge clk);
        host_wr_n = 1; host_rd_n = 1; rev_stb_n = 1; dack_n = 1;
        e_push = 0; e_pop = 0; e_src = 0; e_tag = 0;
        if (kind == 0) e_push = fmode(mode) && ack_low && !fifo_full;
        if (kind == 1) e_pop  = fmode(mode) && ack_low && !fifo_empty;
        if (kind == 2) begin
            e_push = (mode == 3'b011) && dir && !fifo_full;
            e_src  = e_push;
            e_tag  = e_push && busy;
        end
        #1;
        if (kind == 2)      chk_xfer("R6", e_push, e_pop, e_src, e_tag);
        else if (!ack_low)  chk_xfer("R8", e_push, e_pop, e_src, e_tag);
        else if (kind == 0) chk_xfer("R3", e_push, e_pop, e_src, e_tag);
        else                chk_xfer("R4", e_push, e_pop, e_src, e_tag);
        @(negedge clk);
        #1 chk_xfer("R3", 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R7: reset with strobes held low, then released high
        mode = 3'b010; host_wr_n = 0; host_rd_n = 0; dack_n = 0;
        repeat (3) @(negedge clk);
        #1 chk_xfer("R7", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1; host_wr_n = 1; host_rd_n = 1; dack_n = 1;
        #1 chk_xfer("R7", 0, 0, 0, 0);
        @(negedge clk);
        #1 chk_xfer("R7", 0, 0, 0, 0);

        // R1 R2 R5: sweep of request gating inputs
        for (int v = 0; v < 1024; v++) begin
            logic e_set, e_req, space;
            @(negedge clk);
            mode = v[2:0]; dma_en = v[3]; svc_int = v[4]; dir = v[5];
            fifo_full = v[6]; fifo_empty = v[7]; tc = v[8]; dack_n = v[9];
            #1;
            space = (mode == 3'b110) || (!dir && !fifo_full) || (dir && !fifo_empty);
            e_set = fmode(mode) && dma_en && !svc_int && tc && !dack_n;
            e_req = fmode(mode) && dma_en && !svc_int && space && !e_set;
            if (!fmode(mode)) begin
                chk("R1", "dreq", dreq, 1'b0);
                chk("R1", "set_svc", set_svc, 1'b0);
            end else if (e_set) begin
                chk("R5", "dreq", dreq, e_req);
                chk("R5", "set_svc", set_svc, e_set);
            end else begin
                chk("R2", "dreq", dreq, e_req);
                chk("R2", "set_svc", set_svc, e_set);
            end
        end
        @(negedge clk);
        dma_en = 0; svc_int = 0; tc = 0; dack_n = 1;

        // R3 R4 R6 R8: strobe sweep
        for (int v = 0; v < 128; v++) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                mode = v[2:0]; dir = v[3]; fifo_full = v[4]; fifo_empty = v[5];
                strobe_seq(k, v[6], v[0] ^ v[3]);
            end
        end

        // R6: reverse strobe wins over a simultaneous host write
        @(negedge clk);
        mode = 3'b011; dir = 1; fifo_full = 0; fifo_empty = 0;
        @(negedge clk);
        host_wr_n = 0; rev_stb_n = 0; dack_n = 0; periph_busy = 1;
        @(negedge clk);
        host_wr_n = 1; rev_stb_n = 1; dack_n = 1;
        #1 chk_xfer("R6", 1, 0, 1, 1);
        @(negedge clk);
        #1 chk_xfer("R6", 0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule